// File: doc/BRIEF.md
# APB UART Register Front-End

This block is the bus side of a serial port. A CPU reaches it over an APB slave port with four registers: a data register, a read-only status word, a control word and a scaler slot that is only a stub. Received bytes come in on a byte-wide valid/ready input and wait in a receive queue. The CPU drains the queue by reading the data register. A CPU write to the data register sends a byte out as a one-cycle transmit strobe.

One interrupt line pulses for one cycle when a byte is queued or sent, if the control word enables that event. The transmitter never holds data, so the status word always reports it as empty. Control bits for line features such as parity, flow control and loopback are only stored, because the bit-level serial logic sits elsewhere.

Top module: `uart_bus_front`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0x00000006 (bit 1 and bit 2 set), the receive queue is empty, and `irq` and `tx_valid` are low.
- R2: The 8-bit offset selects data at 0x00 and 0x03, status at 0x04, control at 0x08 and scaler at 0x0C. The scaler and every other offset, including 0x10, read 0. Writes to the scaler and to other offsets change nothing.
- R3: The receive queue holds up to RXQ_DEPTH (default 16) bytes and returns them oldest first. While it is full, status bit 10 is set and `rx_ready` is low, so no byte is lost or overwritten.
- R4: A read access phase (psel, penable, !pwrite) at offset 0x00 or 0x03 returns the oldest byte in prdata[7:0] and removes it. A setup phase alone does not remove a byte, and neither does a write to the data register.
- R5: A data read while the queue is empty returns 0 and leaves the queue unchanged.
- R6: Status bit 0 is set while the queue holds at least one unread byte. It clears once the last byte has been read.
- R7: An incoming byte is stored only if control bit 0 is set. With bit 0 clear the byte is accepted and dropped.
- R8: When a byte is stored and control bit 2 is set, `irq` is high for exactly the one cycle after the storing clock edge.
- R9: A write to offset 0x00 or 0x03 while control bit 1 is set raises `tx_valid` for the one cycle after the access edge, with `tx_data` equal to pwdata[7:0]. With bit 1 clear, `tx_valid` stays low.
- R10: A transmit from R9 with control bit 3 set pulses `irq` for one cycle. A receive event and a transmit event on the same edge give one single-cycle pulse.
- R11: Writes to the status word are ignored. A write to the control word stores all 32 bits, and a read returns them unchanged.
- R12: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | Register offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Always no error |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Queue can take a byte |
| tx_data | output | 8 | Byte to send |
| tx_valid | output | 1 | One-cycle send strobe |
| irq | output | 1 | Interrupt pulse |

## Verification
The receive path is driven with several patterns, each aimed at a different fault:
- A three-byte burst read back through both data offsets separates FIFO ordering faults from decode faults at offset 0x03.
- Filling the queue to its depth and pushing one more byte shows whether the full flag, the back-pressure and the overflow guard all work.
- A setup phase with no access phase, and a data write between pushes, show whether a pop can happen outside a read access phase.

The transmit path is tried with its enable bit off and on, at both data offsets and with an upper byte in pwdata. A receive byte and a data write on the same clock edge check that the interrupt pulse is a single cycle and not two.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int OFS_W  = 8;

    localparam logic [OFS_W-1:0] OFS_DATA   = 8'h00;
    localparam logic [OFS_W-1:0] OFS_DATA_B = 8'h03;
    localparam logic [OFS_W-1:0] OFS_STAT   = 8'h04;
    localparam logic [OFS_W-1:0] OFS_CTRL   = 8'h08;
    localparam logic [OFS_W-1:0] OFS_SCAL   = 8'h0C;

    // control word bit positions
    localparam int CB_RX_EN = 0;
    localparam int CB_TX_EN = 1;
    localparam int CB_RX_IE = 2;
    localparam int CB_TX_IE = 3;

    // status word bit positions
    localparam int SB_HAVE_DATA = 0;
    localparam int SB_TX_SHIFT  = 1;
    localparam int SB_TX_QUEUE  = 2;
    localparam int SB_RX_FULL   = 10;

    typedef enum logic [2:0] {
        SEL_DATA,
        SEL_STAT,
        SEL_CTRL,
        SEL_SCAL,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
        case (ofs)
            OFS_DATA, OFS_DATA_B: return SEL_DATA;
            OFS_STAT:             return SEL_STAT;
            OFS_CTRL:             return SEL_CTRL;
            OFS_SCAL:             return SEL_SCAL;
            default:              return SEL_NONE;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input logic have_data,
                                                     input logic rx_full);
        logic [WORD_W-1:0] s;
        s               = '0;
        s[SB_HAVE_DATA] = have_data;
        s[SB_TX_SHIFT]  = 1'b1;
        s[SB_TX_QUEUE]  = 1'b1;
        s[SB_RX_FULL]   = rx_full;
        return s;
    endfunction

endpackage

// File: rtl/uart_fe_rxq.sv
module uart_fe_rxq #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R3: occupancy never exceeds the depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R6: a stored byte with no pop leaves the queue non-empty
    a_r6_push_sets_ready: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> !empty);

endmodule

// File: rtl/uart_fe_evt.sv
module uart_fe_evt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_evt,
    input  logic         tx_evt,
    input  logic         rx_ie,
    input  logic         tx_ie,
    input  logic [W-1:0] tx_byte,
    output logic         irq,
    output logic         tx_valid,
    output logic [W-1:0] tx_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq      <= 1'b0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            irq      <= (rx_evt && rx_ie) || (tx_evt && tx_ie);
            tx_valid <= tx_evt;
            if (tx_evt) tx_data <= tx_byte;
        end
    end

    // R8 / R10: every pulse has a cause on the edge before it
    a_r8_irq_has_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(rx_evt || tx_evt));

    // R9: the send strobe lasts a single cycle unless a new write came
    a_r9_strobe_single: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_evt) |=> !tx_valid);

endmodule

// File: rtl/uart_bus_front.sv
module uart_bus_front
    import uart_fe_pkg::*;
#(
    parameter int RXQ_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [OFS_W-1:0]  paddr,
    input  logic [WORD_W-1:0] pwdata,
    output logic [WORD_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    output logic              irq
);
    reg_sel_e          sel;
    logic              rd_acc, wr_acc;
    logic              q_pop, q_empty, q_full;
    logic [BYTE_W-1:0] q_rdata;
    logic              rx_store, tx_fire;
    logic [WORD_W-1:0] ctrl_q;

    assign sel      = decode_ofs(paddr);
    assign rd_acc   = psel && penable && !pwrite;
    assign wr_acc   = psel && penable && pwrite;
    assign q_pop    = rd_acc && (sel == SEL_DATA);
    assign rx_ready = !q_full;
    assign rx_store = rx_valid && rx_ready && ctrl_q[CB_RX_EN];
    assign tx_fire  = wr_acc && (sel == SEL_DATA) && ctrl_q[CB_TX_EN];
    assign pready   = 1'b1;
    assign pslverr  = 1'b0;

    always_ff @(posedge clk) begin
        if (rst)                              ctrl_q <= '0;
        else if (wr_acc && sel == SEL_CTRL)   ctrl_q <= pwdata;
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (sel)
                SEL_DATA: prdata = {{(WORD_W-BYTE_W){1'b0}}, q_rdata};
                SEL_STAT: prdata = pack_status(!q_empty, q_full);
                SEL_CTRL: prdata = ctrl_q;
                default:  prdata = '0;
            endcase
        end
    end

    uart_fe_rxq #(.DEPTH(RXQ_DEPTH), .W(BYTE_W)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_store),
        .wdata (rx_data),
        .pop   (q_pop),
        .rdata (q_rdata),
        .empty (q_empty),
        .full  (q_full)
    );

    uart_fe_evt #(.W(BYTE_W)) u_evt (
        .clk      (clk),
        .rst      (rst),
        .rx_evt   (rx_store),
        .tx_evt   (tx_fire),
        .rx_ie    (ctrl_q[CB_RX_IE]),
        .tx_ie    (ctrl_q[CB_TX_IE]),
        .tx_byte  (pwdata[BYTE_W-1:0]),
        .irq      (irq),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

    // R11: a control write is held in full on the next cycle
    a_r11_ctrl_store: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && sel == SEL_CTRL) |=> (ctrl_q == $past(pwdata)));

    // R9: a send strobe follows only a write made with transmit enabled
    a_r9_tx_needs_enable: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> ($past(wr_acc) && $past(ctrl_q[CB_TX_EN])));

    // R5: reading the data register of an empty queue yields zero
    a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (q_pop && q_empty) |-> (prdata == '0));

endmodule

// File: tb/sim_uart_bus_front.sv
`timescale 1ns/1ps
module sim_uart_bus_front;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid, irq;

    int tests = 0;
    int fails = 0;
    logic last_ready;

    always #10 clk = ~clk;

    uart_bus_front #(.RXQ_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        chk("R12 pready", {31'b0, pready}, 32'd1);
        chk("R12 pslverr", {31'b0, pslverr}, 32'd0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        #1 last_ready = rx_ready;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
        apb_read(8'h04, d); chk("R1 status", d, 32'h6);
        apb_read(8'h08, d); chk("R1 control", d, 32'h0);
        apb_read(8'h00, d); chk("R1 R5 empty data", d, 32'h0);
    endtask

    task automatic t_decode();
        logic [31:0] d;
        apb_write(8'h0C, 32'hFFFF_FFFF);
        apb_read(8'h0C, d); chk("R2 scaler", d, 32'h0);
        apb_read(8'h10, d); chk("R2 off 0x10", d, 32'h0);
        apb_read(8'hFC, d); chk("R2 off 0xFC", d, 32'h0);
        apb_write(8'h10, 32'h0000_000F);
        apb_read(8'h08, d); chk("R2 stray write ctrl", d, 32'h0);
    endtask

    task automatic t_rx_disabled();
        logic [31:0] d;
        push(8'hAA);
        apb_read(8'h04, d); chk("R7 no data ready", d, 32'h6);
        apb_read(8'h00, d); chk("R7 dropped byte", d, 32'h0);
    endtask

    task automatic t_rx_order();
        logic [31:0] d;
        apb_write(8'h08, 32'h1);
        push(8'h11); push(8'h22); push(8'h33);
        apb_read(8'h04, d); chk("R6 ready set", d, 32'h7);
        apb_read(8'h00, d); chk("R3 R4 first", d, 32'h11);
        apb_read(8'h03, d); chk("R4 offset 3", d, 32'h22);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = 8'h00; penable = 1'b0;
        @(negedge clk); @(negedge clk);
        psel = 1'b0;
        apb_write(8'h00, 32'h99);
        apb_read(8'h00, d); chk("R4 no pop on setup or write", d, 32'h33);
        apb_read(8'h04, d); chk("R6 ready clear", d, 32'h6);
        apb_read(8'h00, d); chk("R5 empty read", d, 32'h0);
        push(8'h44);
        apb_read(8'h00, d); chk("R5 queue intact after empty read", d, 32'h44);
    endtask

    task automatic t_full();
        logic [31:0] d;
        for (int i = 0; i < DEPTH; i++) push(8'(i + 8'h40));
        apb_read(8'h04, d); chk("R3 full flag", d, 32'h407);
        chk("R3 rx_ready low", {31'b0, rx_ready}, 32'd0);
        push(8'hEE);
        chk("R3 extra refused", {31'b0, last_ready}, 32'd0);
        for (int i = 0; i < DEPTH; i++) begin
            apb_read(8'h00, d); chk("R3 drain order", d, 32'(i + 8'h40));
        end
        apb_read(8'h00, d); chk("R3 nothing extra", d, 32'h0);
    endtask

    task automatic t_rx_irq();
        logic [31:0] d;
        apb_write(8'h08, 32'h5);
        push(8'h5A);
        chk("R8 irq pulse", {31'b0, irq}, 32'd1);
        @(negedge clk);
        chk("R8 irq one cycle", {31'b0, irq}, 32'd0);
        apb_write(8'h08, 32'h1);
        push(8'h5B);
        chk("R8 irq masked", {31'b0, irq}, 32'd0);
        apb_read(8'h00, d); chk("R8 byte a", d, 32'h5A);
        apb_read(8'h00, d); chk("R8 byte b", d, 32'h5B);
    endtask

    task automatic t_tx();
        apb_write(8'h08, 32'h0);
        apb_write(8'h00, 32'h77);
        chk("R9 disabled no strobe", {31'b0, tx_valid}, 32'd0);
        apb_write(8'h08, 32'h2);
        apb_write(8'h00, 32'h1A5);
        chk("R9 strobe", {31'b0, tx_valid}, 32'd1);
        chk("R9 byte", {24'b0, tx_data}, 32'hA5);
        chk("R10 no irq without enable", {31'b0, irq}, 32'd0);
        @(negedge clk);
        chk("R9 strobe one cycle", {31'b0, tx_valid}, 32'd0);
        apb_write(8'h03, 32'h3C);
        chk("R9 offset 3 byte", {23'b0, tx_valid, tx_data}, 32'h13C);
        apb_write(8'h08, 32'hA);
        apb_write(8'h00, 32'h01);
        chk("R10 tx irq", {31'b0, irq}, 32'd1);
    endtask

    task automatic t_coincide();
        logic [31:0] d;
        apb_write(8'h08, 32'hF);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'h62; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1; rx_valid = 1'b1; rx_data = 8'h61;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; rx_valid = 1'b0;
        chk("R10 combined pulse", {30'b0, irq, tx_valid}, 32'h3);
        @(negedge clk);
        chk("R10 single pulse", {31'b0, irq}, 32'd0);
        apb_read(8'h00, d); chk("R10 rx byte kept", d, 32'h61);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        apb_write(8'h04, 32'hFFFF_FFFF);
        apb_read(8'h04, d); chk("R11 status read-only", d, 32'h6);
        apb_write(8'h08, 32'hDEAD_BEF0);
        apb_read(8'h08, d); chk("R11 control 32-bit", d, 32'hDEAD_BEF0);
        apb_write(8'h08, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_decode();
        t_rx_disabled();
        t_rx_order();
        t_full();
        t_rx_irq();
        t_tx();
        t_coincide();
        t_regs();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule